// File: doc/BRIEF.md
# First/Next Error Capture Logger

This block gathers per-cycle error strobes from a memory interface and a bus interface and keeps two status words. The first-error word holds only the error condition(s) that arrived while it was empty. Any error that arrives after that goes into the next-error word. When the first error includes a double-error-detect (DED) event, the block also freezes that event's context: the 8 ECC checkbits of the failing word, plus a 16-bit transaction-info word that holds the transaction ID and the failing data chunk.

Software reads the words through a small register port with a combinational read mux. It clears status bits by writing ones to the first-error word. A single write-one-to-clear acts on both status words at once. If a clear and a new hardware error fall in the same clock cycle, the block records the new error in the first-error word, sets a dedicated collision bit, and leaves the context registers as they were. The collision bit marks that context as stale. An `any_err` flag tells a service routine that work is pending.

Top module: `err_first_next_log`

## Requirements
- R1: After reset, and after any later reset, all four readable registers are zero and `any_err` is 0.
- R2: Status bit positions are fixed: DED is bit 0, length-field mismatch (`proto_err[0]`) is bit 27, write-data protocol error (`proto_err[1]`) is bit 28, ready/busy handshake error (`proto_err[2]`) is bit 29, receive-length error (`proto_err[3]`) is bit 30, and collision is bit 31. With the first-error word (address 0) empty and no clear in progress, the error strobes of a cycle appear in that word in the next cycle.
- R3: While the first-error word is non-zero, a new error leaves that word unchanged and sets its bit in the next-error word (address 1).
- R4: A write to address 0 clears every first-error and next-error bit where the write data holds a 1. Bits written with 0 keep their value.
- R5: Writes to addresses 1, 2 and 3 change no register.
- R6: A DED recorded as a first error loads the checkbits into address 2, bits 7:0. It also loads address 3 with the transaction ID in bits 5:0, the chunk index in bits 8:6, and zeros in bits 15:9.
- R7: A DED that lands in the next-error word leaves both context registers unchanged.
- R8: When a write to address 0 carries a 1 in any of bits 30:0 and a hardware error occurs in the same cycle, the new error bits are set in the first-error word, bit 31 is set, and the context registers keep their old values.
- R9: Bit 31 is never 1 unless some other first-error bit is 1. Bit 31 clears when it is written with 1, and it also clears when all other first-error bits are cleared.
- R10: `any_err` is 1 exactly when bits 30:0 of either status word hold a 1.
- R11: Once the first-error word has been emptied, the next error is captured as a first error again, and a DED among those errors reloads the context.
- R12: Several sources asserted in the same cycle while the first-error word is empty are all recorded there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ded_err | input | 1 | Double-error-detect strobe |
| ded_ecc | input | 8 | ECC checkbits of the failing word |
| ded_tid | input | 6 | Transaction ID of the failing access |
| ded_chunk | input | 3 | Failing data chunk index |
| proto_err | input | 4 | Bus protocol error strobes (see R2) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 first, 1 next, 2 checkbits, 3 transaction info |
| reg_wdata | input | 32 | Write data (ones clear at address 0) |
| reg_rdata | output | 32 | Read data of the selected register |
| any_err | output | 1 | Pending error flag |

## Verification
The assertions check several rules on every cycle. The first-error word holds while it is non-zero and no clear is written. It loads exactly the strobes of a cycle when it is empty. Cleared bits read zero in both words after a clear with no error in the same cycle. A collision sets bit 31 and freezes the context, bit 31 never appears alone, the next-error word never carries bit 31, and the context holds while a first error is pending. Only the bench's scenarios can show the following: the exact bit mapping of each source, the field layout of the transaction-info word, that writes to the other addresses are ignored, that capture restarts after a full clear, and that a mid-run reset brings everything back to zero.

// File: rtl/elog_pkg.sv
package elog_pkg;

   typedef enum logic [1:0] {
      SEL_FIRST = 2'd0,
      SEL_NEXT  = 2'd1,
      SEL_CHK   = 2'd2,
      SEL_INFO  = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/elog_src_map.sv
module elog_src_map #(
   parameter int LO_W     = 31,
   parameter int NPROTO   = 4,
   parameter int PROTO_HI = 30,
   parameter int DED_POS  = 0
) (
   input  logic              ded_err,
   input  logic [NPROTO-1:0] proto_err,
   output logic [LO_W-1:0]   hw_evt
);

   localparam int PROTO_LO = PROTO_HI - NPROTO + 1;

   if (PROTO_HI >= LO_W) begin : g_bad_hi
      $error("protocol bits overlap the collision bit");
   end
   if (DED_POS >= PROTO_LO) begin : g_bad_ded
      $error("DED position overlaps protocol bits");
   end

   logic [LO_W-1:0] proto_map;
   logic [LO_W-1:0] ded_map;

   for (genvar b = 0; b < LO_W; b++) begin : g_bit
      if (b >= PROTO_LO && b <= PROTO_HI) begin : g_proto
         assign proto_map[b] = proto_err[b-PROTO_LO];
      end else begin : g_none
         assign proto_map[b] = 1'b0;
      end
      if (b == DED_POS) begin : g_ded
         assign ded_map[b] = ded_err;
      end else begin : g_noded
         assign ded_map[b] = 1'b0;
      end
   end

   assign hw_evt = proto_map | ded_map;

endmodule

// File: rtl/elog_status.sv
module elog_status #(
   parameter int STAT_W  = 32,
   parameter int DED_POS = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-2:0] hw_evt,
   input  logic [STAT_W-1:0] clr,
   output logic [STAT_W-1:0] first_q,
   output logic [STAT_W-1:0] next_q,
   output logic              ctx_load,
   output logic              collide
);

   localparam int LO_W = STAT_W - 1;

   if (STAT_W < 8) begin : g_bad_w
      $error("status word too narrow");
   end

   logic [LO_W-1:0] clr_lo;
   logic [LO_W-1:0] f_lo;
   logic [LO_W-1:0] n_lo;
   logic            f_top;
   logic            first_empty;

   assign clr_lo      = clr[LO_W-1:0];
   assign first_empty = (first_q == '0);
   assign collide     = (|clr_lo) && (|hw_evt);

   always_comb begin
      ctx_load = 1'b0;
      f_lo     = first_q[LO_W-1:0];
      n_lo     = next_q[LO_W-1:0];
      if (collide) begin
         f_lo = (f_lo & ~clr_lo) | hw_evt;
         n_lo = n_lo & ~clr_lo;
      end else if (first_empty) begin
         f_lo     = hw_evt;
         n_lo     = n_lo & ~clr_lo;
         ctx_load = hw_evt[DED_POS];
      end else begin
         f_lo = f_lo & ~clr_lo;
         n_lo = (n_lo | hw_evt) & ~clr_lo;
      end
      f_top = (collide | (first_q[LO_W] & ~clr[LO_W])) & (|f_lo);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         first_q <= '0;
         next_q  <= '0;
      end else begin
         first_q <= {f_top, f_lo};
         next_q  <= {1'b0, n_lo};
      end
   end

   p_first_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (first_q == '0 && clr == '0) |=> first_q[LO_W-1:0] == $past(hw_evt));

   p_first_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (first_q != '0 && clr == '0) |=> first_q == $past(first_q));

   p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr != '0 && hw_evt == '0) |=>
         ((first_q & $past(clr)) == '0 && (next_q[LO_W-1:0] & $past(clr_lo)) == '0));

   p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
      collide |=> first_q[LO_W] && ((first_q[LO_W-1:0] & $past(hw_evt)) == $past(hw_evt)));

   p_lone_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
      first_q[LO_W] |-> (first_q[LO_W-1:0] != '0));

   p_next_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !next_q[LO_W]);

endmodule

// File: rtl/elog_ctx.sv
module elog_ctx #(
   parameter int ECC_W   = 8,
   parameter int TID_W   = 6,
   parameter int CHUNK_W = 3,
   parameter int INFO_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [ECC_W-1:0]   ecc_in,
   input  logic [TID_W-1:0]   tid_in,
   input  logic [CHUNK_W-1:0] chunk_in,
   output logic [ECC_W-1:0]   ecc_q,
   output logic [INFO_W-1:0]  info_q
);

   localparam int USED_W = TID_W + CHUNK_W;
   localparam int PAD_W  = INFO_W - USED_W;

   if (USED_W > INFO_W) begin : g_bad_info
      $error("transaction info fields exceed the word");
   end

   logic [INFO_W-1:0] info_d;

   if (PAD_W > 0) begin : g_pad
      assign info_d = {{PAD_W{1'b0}}, chunk_in, tid_in};
   end else begin : g_nopad
      assign info_d = {chunk_in, tid_in};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ecc_q  <= '0;
         info_q <= '0;
      end else if (load) begin
         ecc_q  <= ecc_in;
         info_q <= info_d;
      end
   end

endmodule

// File: rtl/err_first_next_log.sv
module err_first_next_log
   import elog_pkg::*;
#(
   parameter int STAT_W   = 32,
   parameter int ECC_W    = 8,
   parameter int TID_W    = 6,
   parameter int CHUNK_W  = 3,
   parameter int INFO_W   = 16,
   parameter int NPROTO   = 4,
   parameter int PROTO_HI = 30,
   parameter int DED_POS  = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ded_err,
   input  logic [ECC_W-1:0]   ded_ecc,
   input  logic [TID_W-1:0]   ded_tid,
   input  logic [CHUNK_W-1:0] ded_chunk,
   input  logic [NPROTO-1:0]  proto_err,
   input  logic               reg_wr,
   input  logic [1:0]         reg_addr,
   input  logic [STAT_W-1:0]  reg_wdata,
   output logic [STAT_W-1:0]  reg_rdata,
   output logic               any_err
);

   localparam int LO_W = STAT_W - 1;

   if (ECC_W > STAT_W || INFO_W > STAT_W) begin : g_bad_ctx
      $error("context register wider than read port");
   end

   logic [LO_W-1:0]   hw_evt;
   logic [STAT_W-1:0] clr;
   logic [STAT_W-1:0] first_q;
   logic [STAT_W-1:0] next_q;
   logic              ctx_load;
   logic              collide;
   logic [ECC_W-1:0]  ecc_q;
   logic [INFO_W-1:0] info_q;
   reg_sel_e          sel;

   assign sel = reg_sel_e'(reg_addr);
   assign clr = (reg_wr && sel == SEL_FIRST) ? reg_wdata : '0;

   elog_src_map #(
      .LO_W(LO_W), .NPROTO(NPROTO), .PROTO_HI(PROTO_HI), .DED_POS(DED_POS)
   ) u_map (
      .ded_err(ded_err), .proto_err(proto_err), .hw_evt(hw_evt)
   );

   elog_status #(
      .STAT_W(STAT_W), .DED_POS(DED_POS)
   ) u_stat (
      .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .clr(clr),
      .first_q(first_q), .next_q(next_q), .ctx_load(ctx_load), .collide(collide)
   );

   elog_ctx #(
      .ECC_W(ECC_W), .TID_W(TID_W), .CHUNK_W(CHUNK_W), .INFO_W(INFO_W)
   ) u_ctx (
      .clk(clk), .rst_n(rst_n), .load(ctx_load),
      .ecc_in(ded_ecc), .tid_in(ded_tid), .chunk_in(ded_chunk),
      .ecc_q(ecc_q), .info_q(info_q)
   );

   always_comb begin
      unique case (sel)
         SEL_FIRST: reg_rdata = first_q;
         SEL_NEXT:  reg_rdata = next_q;
         SEL_CHK:   reg_rdata = {{(STAT_W-ECC_W){1'b0}}, ecc_q};
         default:   reg_rdata = {{(STAT_W-INFO_W){1'b0}}, info_q};
      endcase
   end

   assign any_err = (|first_q[LO_W-1:0]) | (|next_q[LO_W-1:0]);

   p_ctx_stale_r8: assert property (@(posedge clk) disable iff (!rst_n)
      collide |=> (ecc_q == $past(ecc_q) && info_q == $past(info_q)));

   p_ctx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (first_q != '0) |=> (ecc_q == $past(ecc_q) && info_q == $past(info_q)));

   p_any_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
      first_q[LO_W] |-> any_err);

endmodule

// File: tb/err_first_next_log_test.sv
module err_first_next_log_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ded_err = 1'b0;
   logic [7:0]  ded_ecc = '0;
   logic [5:0]  ded_tid = '0;
   logic [2:0]  ded_chunk = '0;
   logic [3:0]  proto_err = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        any_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   err_first_next_log uut (
      .clk(clk), .rst_n(rst_n), .ded_err(ded_err), .ded_ecc(ded_ecc),
      .ded_tid(ded_tid), .ded_chunk(ded_chunk), .proto_err(proto_err),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .any_err(any_err)
   );

   typedef struct packed {
      logic        ded;
      logic [7:0]  ecc;
      logic [5:0]  tid;
      logic [2:0]  chk;
      logic [3:0]  pe;
      logic        wr;
      logic [31:0] wd;
      logic [31:0] ef;
      logic [31:0] en;
      logic [7:0]  ee;
      logic [15:0] ei;
      logic        ea;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b0, 32'h0, 32'h0000_0000, 32'h0000_0000, 8'h00, 16'h0000, 1'b0},
      '{1'b0, 8'h00, 6'h00, 3'd0, 4'b0001, 1'b0, 32'h0, 32'h0800_0000, 32'h0000_0000, 8'h00, 16'h0000, 1'b1},
      '{1'b1, 8'hA5, 6'h2A, 3'd5, 4'b0000, 1'b0, 32'h0, 32'h0800_0000, 32'h0000_0001, 8'h00, 16'h0000, 1'b1},
      '{1'b0, 8'h00, 6'h00, 3'd0, 4'b1000, 1'b0, 32'h0, 32'h0800_0000, 32'h4000_0001, 8'h00, 16'h0000, 1'b1},
      '{1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b1, 32'h0800_0001, 32'h0000_0000, 32'h4000_0000, 8'h00, 16'h0000, 1'b1},
      '{1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b1, 32'h0, 32'h0000_0000, 32'h4000_0000, 8'h00, 16'h0000, 1'b1},
      '{1'b1, 8'h3C, 6'h15, 3'd3, 4'b0000, 1'b0, 32'h0, 32'h0000_0001, 32'h4000_0000, 8'h3C, 16'h00D5, 1'b1},
      '{1'b1, 8'hFF, 6'h3F, 3'd7, 4'b0000, 1'b0, 32'h0, 32'h0000_0001, 32'h4000_0001, 8'h3C, 16'h00D5, 1'b1},
      '{1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 8'h3C, 16'h00D5, 1'b0},
      '{1'b1, 8'h81, 6'h01, 3'd2, 4'b0110, 1'b0, 32'h0, 32'h3000_0001, 32'h0000_0000, 8'h81, 16'h0081, 1'b1},
      '{1'b1, 8'h77, 6'h07, 3'd1, 4'b0001, 1'b1, 32'h3000_0001, 32'h8800_0001, 32'h0000_0000, 8'h81, 16'h0081, 1'b1},
      '{1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b1, 32'h8000_0000, 32'h0800_0001, 32'h0000_0000, 8'h81, 16'h0081, 1'b1},
      '{1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b1, 32'h0800_0001, 32'h0000_0000, 32'h0000_0000, 8'h81, 16'h0081, 1'b0}
   };

   function automatic string vtag(int i);
      case (i)
         0:       return "R1";
         1:       return "R2";
         2, 3:    return "R3/R7";
         4, 5:    return "R4";
         6:       return "R6/R11";
         7:       return "R7";
         8:       return "R4/R10";
         9:       return "R12/R6";
         10:      return "R8";
         11:      return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
      reg_wr   = 1'b0;
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic drive(input logic ded, input logic [7:0] ecc, input logic [5:0] tid,
                        input logic [2:0] chk, input logic [3:0] pe,
                        input logic wr, input logic [1:0] a, input logic [31:0] wd);
      @(negedge clk);
      ded_err = ded; ded_ecc = ecc; ded_tid = tid; ded_chunk = chk;
      proto_err = pe; reg_wr = wr; reg_addr = a; reg_wdata = wd;
      @(posedge clk);
      #1;
      ded_err = 1'b0; proto_err = '0; reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic check_all(input string req, input logic [31:0] ef, input logic [31:0] en,
                            input logic [7:0] ee, input logic [15:0] ei, input logic ea);
      logic [31:0] d;
      read_reg(2'd0, d); check(req, "first", d, ef);
      read_reg(2'd1, d); check(req, "next", d, en);
      read_reg(2'd2, d); check(req, "chkbits", d, {24'h0, ee});
      read_reg(2'd3, d); check(req, "txinfo", d, {16'h0, ei});
      check(req, "any_err", {31'h0, any_err}, {31'h0, ea});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check_all("R1", 32'h0, 32'h0, 8'h00, 16'h0000, 1'b0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      for (int i = 0; i < NV; i++) begin
         drive(TBL[i].ded, TBL[i].ecc, TBL[i].tid, TBL[i].chk, TBL[i].pe,
               TBL[i].wr, 2'd0, TBL[i].wd);
         check_all(vtag(i), TBL[i].ef, TBL[i].en, TBL[i].ee, TBL[i].ei, TBL[i].ea);
      end

      // R2: handshake error maps to bit 29
      drive(1'b0, 8'h00, 6'h00, 3'd0, 4'b0100, 1'b0, 2'd0, 32'h0);
      check_all("R2", 32'h2000_0000, 32'h0, 8'h81, 16'h0081, 1'b1);
      // R5: writes to addresses 1..3 are ignored
      drive(1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b1, 2'd2, 32'hFFFF_FFFF);
      drive(1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b1, 2'd3, 32'hFFFF_FFFF);
      drive(1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b1, 2'd1, 32'h2000_0000);
      check_all("R5", 32'h2000_0000, 32'h0, 8'h81, 16'h0081, 1'b1);
      drive(1'b0, 8'h00, 6'h00, 3'd0, 4'b0010, 1'b0, 2'd0, 32'h0);
      drive(1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b1, 2'd1, 32'h1000_0000);
      check_all("R5", 32'h2000_0000, 32'h1000_0000, 8'h81, 16'h0081, 1'b1);
      // R8: collision with a DED, context stays stale
      drive(1'b1, 8'h11, 6'h02, 3'd4, 4'b0000, 1'b1, 2'd0, 32'h2000_0000);
      check_all("R8", 32'h8000_0001, 32'h1000_0000, 8'h81, 16'h0081, 1'b1);
      // R9: clearing the last other bit drops bit 31
      drive(1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b1, 2'd0, 32'h0000_0001);
      check_all("R9", 32'h0, 32'h1000_0000, 8'h81, 16'h0081, 1'b1);
      // R10: flag follows the next-error word alone
      drive(1'b0, 8'h00, 6'h00, 3'd0, 4'b0000, 1'b1, 2'd0, 32'h1000_0000);
      check_all("R10", 32'h0, 32'h0, 8'h81, 16'h0081, 1'b0);
      // R11: full capture again after emptying, with new context
      drive(1'b1, 8'h5A, 6'h3E, 3'd6, 4'b0000, 1'b0, 2'd0, 32'h0);
      check_all("R11", 32'h0000_0001, 32'h0, 8'h5A, 16'h01BE, 1'b1);
      // R1: reset in mid-run
      drive(1'b0, 8'h00, 6'h00, 3'd0, 4'b1111, 1'b0, 2'd0, 32'h0);
      @(negedge clk);
      rst_n = 1'b0;
      #3;
      check_all("R1", 32'h0, 32'h0, 8'h00, 16'h0000, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule